// File: doc/BRIEF.md
# Dual Interval Timer

A memory-mapped timer with two identical, independent count channels. Every channel holds three registers: a control word, a load value and a live counter. Software picks the count direction, writes a start value and sets the run bit. The counter then steps once per clock until it reaches its terminal value. That value is zero when counting down and all-ones when counting up. At terminal count the channel sets a sticky interrupt flag. It can also emit a single-cycle pulse on its generate output. With auto-reload on, it starts over from the load value.

A reload costs one extra cycle, so the distance between generate pulses is the load value plus two when counting down. When counting up it is the maximum count minus the load value, plus two. Programmable periods therefore run from 2 cycles to the maximum count plus 2. Software converts wall-clock time into cycle counts.

Registers use byte addresses. Channel 0 occupies 0x00 (control), 0x04 (load) and 0x08 (counter). Channel 1 uses the same layout at 0x10, 0x14 and 0x18. The counter width is the parameter `CNT_W`, from 8 to 32 bits. Three control bits have no effect and are only kept for read-back: capture enable, PWM enable and cascade.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every register reads zero and both generate and interrupt outputs are low. Channel `c` is selected by address bit 4. Address bits 3:2 select control (0), load (1) or counter (2). Value 3 reads zero. Address bits 1:0 are ignored.
- R2: Control bits, from bit 0: 0 mode, 1 direction (1 = down), 2 generate enable, 3 capture enable, 4 auto-reload, 5 load, 6 interrupt enable, 7 run, 8 interrupt flag, 9 PWM enable, 10 enable-all, 11 cascade. Bits 0, 3, 9, 10 and 11 read back exactly as written, and bits 0, 3, 9 and 11 do not affect counting or the outputs. Bits 31:12 read zero.
- R3: The load register keeps the low `CNT_W` bits of the write data and reads back zero-extended.
- R4: While the load bit is 1, the counter is set to the load register value on every clock.
- R5: Down-counting with auto-reload gives generate pulses spaced load + 2 cycles apart (2 when load is 0).
- R6: Up-counting with auto-reload gives generate pulses spaced max − load + 2 cycles apart, where max = 2^CNT_W − 1.
- R7: With auto-reload clear, the channel stops at terminal count. The counter holds zero (down) or max (up), the run bit clears and exactly one generate pulse appears.
- R8: Terminal count sets the interrupt flag. Writing 1 to bit 8 clears it, and writing 0 leaves it unchanged. If a terminal count and a clearing write fall in the same cycle, the flag is set.
- R9: The interrupt output of a channel equals its flag ANDed with its interrupt enable bit.
- R10: A control write with bit 10 set, to either channel, sets the run bit of both channels on the same clock edge.
- R11: Each generate pulse lasts one cycle. No pulse appears while generate enable is clear, and the flag is still set.
- R12: Writes to the counter offset have no effect. While the run bit and the load bit are both clear, the counter does not change.
- R13: The two channels count with their own settings at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| gen_out | output | 2 | Per-channel single-cycle terminal-count pulse |
| irq_out | output | 2 | Per-channel interrupt (flag AND enable) |

## Verification
The bench measures pulse spacing at both ends of the range. The shortest case is load 0 counting down, and load at max counting up. A design without the reload cycle would give a period of one, or pulses that never return low. The longest case is up-counting from zero, where an off-by-one in the terminal compare shows up as max+1 or max+3. Random loads in both directions, on both channels, are compared against the two period formulas. That catches swapped directions and one-off reloads. One-shot runs check that the counter parks on the terminal value with the run bit cleared; a design that wrapped would produce extra pulses. The flag is checked for write-1-clear versus write-0 behaviour, and the counter offset is written to confirm it ignores writes.

// File: rtl/dit_pkg.sv
package dit_pkg;

    localparam int CTRL_W = 12;

    // control bit positions (software-visible, fixed)
    localparam int B_MODE  = 0;
    localparam int B_DOWN  = 1;
    localparam int B_GEN   = 2;
    localparam int B_CAPT  = 3;
    localparam int B_ARLD  = 4;
    localparam int B_LOAD  = 5;
    localparam int B_IEN   = 6;
    localparam int B_RUN   = 7;
    localparam int B_FLAG  = 8;
    localparam int B_PWM   = 9;
    localparam int B_ENALL = 10;
    localparam int B_CASC  = 11;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_LOAD  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/dit_bus_decode.sv
module dit_bus_decode
    import dit_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int CH_W = 1
) (
    input  logic [CH_W+1:0]  word_addr,
    input  logic             wr,
    input  logic             enall_bit,
    output logic [NCH-1:0]   ctrl_wr,
    output logic [NCH-1:0]   load_wr,
    output logic             enall_set,
    output logic [CH_W-1:0]  ch_idx,
    output reg_sel_e         sel
);

    assign ch_idx = word_addr[CH_W+1:2];
    assign sel    = reg_sel_e'(word_addr[1:0]);

    for (genvar i = 0; i < NCH; i++) begin : g_strobe
        assign ctrl_wr[i] = wr && (ch_idx == CH_W'(i)) && (sel == SEL_CTRL);
        assign load_wr[i] = wr && (ch_idx == CH_W'(i)) && (sel == SEL_LOAD);
    end

    // enable-all reaches every channel from a write to any control word
    assign enall_set = wr && (sel == SEL_CTRL) && enall_bit;

endmodule

// File: rtl/dit_read_mux.sv
module dit_read_mux
    import dit_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CH_W  = 1,
    parameter int CNT_W = 32,
    parameter int DW    = 32
) (
    input  logic [NCH-1:0][CTRL_W-1:0] ch_ctrl,
    input  logic [NCH-1:0][CNT_W-1:0]  ch_load,
    input  logic [NCH-1:0][CNT_W-1:0]  ch_cnt,
    input  logic [CH_W-1:0]            ch_idx,
    input  reg_sel_e                   sel,
    output logic [DW-1:0]              rdata
);

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL:  rdata = DW'(ch_ctrl[ch_idx]);
            SEL_LOAD:  rdata = DW'(ch_load[ch_idx]);
            SEL_COUNT: rdata = DW'(ch_cnt[ch_idx]);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/dit_channel.sv
module dit_channel
    import dit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              load_wr,
    input  logic              enall_set,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [CNT_W-1:0]  load_wdata,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CNT_W-1:0]  load_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              gen_o,
    output logic              irq_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CNT_W-1:0]  load;
        logic [CNT_W-1:0]  cnt;
        logic              reload_wait;  // extra cycle spent on a reload
        logic              gen;
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic             count_down;
    logic [CNT_W-1:0] term_val;
    logic             tc_hit;

    assign count_down = st_q.ctrl[B_DOWN];
    assign term_val   = count_down ? '0 : CNT_MAX;

    always_comb begin
        st_d     = st_q;
        st_d.gen = 1'b0;
        tc_hit   = 1'b0;

        // counting engine, driven by the registered control word
        if (st_q.ctrl[B_LOAD]) begin
            st_d.cnt         = st_q.load;
            st_d.reload_wait = 1'b0;
        end else if (st_q.ctrl[B_RUN]) begin
            if (st_q.reload_wait) begin
                st_d.cnt         = st_q.load;
                st_d.reload_wait = 1'b0;
            end else if (st_q.cnt == term_val) begin
                tc_hit   = 1'b1;
                st_d.gen = st_q.ctrl[B_GEN];
                if (st_q.ctrl[B_ARLD]) begin
                    st_d.reload_wait = 1'b1;
                end else begin
                    st_d.ctrl[B_RUN] = 1'b0;
                end
            end else begin
                st_d.cnt = count_down ? (st_q.cnt - CNT_ONE) : (st_q.cnt + CNT_ONE);
            end
        end

        // software writes take precedence over the one-shot stop
        if (ctrl_wr) begin
            st_d.ctrl         = ctrl_wdata;
            st_d.ctrl[B_FLAG] = st_q.ctrl[B_FLAG] & ~ctrl_wdata[B_FLAG];
        end
        if (enall_set) begin
            st_d.ctrl[B_RUN] = 1'b1;
        end
        // a terminal count wins over a clearing write
        if (tc_hit) begin
            st_d.ctrl[B_FLAG] = 1'b1;
        end
        if (load_wr) begin
            st_d.load = load_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o  = st_q.ctrl;
    assign load_o  = st_q.load;
    assign count_o = st_q.cnt;
    assign gen_o   = st_q.gen;
    assign irq_o   = st_q.ctrl[B_FLAG] & st_q.ctrl[B_IEN];

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter  int CNT_W  = 32,
    localparam int NCH    = 2,
    localparam int CH_W   = $clog2(NCH),
    localparam int ADDR_W = CH_W + 4,
    localparam int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NCH-1:0]    gen_out,
    output logic [NCH-1:0]    irq_out
);

    logic [NCH-1:0]             ctrl_wr;
    logic [NCH-1:0]             load_wr;
    logic                       enall_set;
    logic [CH_W-1:0]            ch_idx;
    reg_sel_e                   sel;
    logic [NCH-1:0][CTRL_W-1:0] ch_ctrl;
    logic [NCH-1:0][CNT_W-1:0]  ch_load;
    logic [NCH-1:0][CNT_W-1:0]  ch_cnt;
    logic                       unused_addr;
    logic                       unused_wdata;

    // byte lanes within a word are not decoded
    assign unused_addr  = ^bus_addr[1:0];
    assign unused_wdata = ^bus_wdata;

    dit_bus_decode #(
        .NCH  (NCH),
        .CH_W (CH_W)
    ) u_decode (
        .word_addr (bus_addr[ADDR_W-1:2]),
        .wr        (bus_wr),
        .enall_bit (bus_wdata[B_ENALL]),
        .ctrl_wr   (ctrl_wr),
        .load_wr   (load_wr),
        .enall_set (enall_set),
        .ch_idx    (ch_idx),
        .sel       (sel)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dit_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_wr    (ctrl_wr[i]),
            .load_wr    (load_wr[i]),
            .enall_set  (enall_set),
            .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
            .load_wdata (bus_wdata[CNT_W-1:0]),
            .ctrl_o     (ch_ctrl[i]),
            .load_o     (ch_load[i]),
            .count_o    (ch_cnt[i]),
            .gen_o      (gen_out[i]),
            .irq_o      (irq_out[i])
        );
    end

    dit_read_mux #(
        .NCH   (NCH),
        .CH_W  (CH_W),
        .CNT_W (CNT_W),
        .DW    (DW)
    ) u_rmux (
        .ch_ctrl (ch_ctrl),
        .ch_load (ch_load),
        .ch_cnt  (ch_cnt),
        .ch_idx  (ch_idx),
        .sel     (sel),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/dit_checker.sv
module dit_checker
    import dit_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int NCH   = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ctrl_strobe,
    input logic                       enall_bit,
    input logic [NCH-1:0]             gen_out,
    input logic [NCH-1:0]             irq_out,
    input logic [NCH-1:0][CTRL_W-1:0] ch_ctrl,
    input logic [NCH-1:0][CNT_W-1:0]  ch_load,
    input logic [NCH-1:0][CNT_W-1:0]  ch_cnt
);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R11: generate pulse never lasts more than one cycle
        p_gen_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
            gen_out[i] |=> !gen_out[i]);

        // R8: every generate pulse coincides with a raised flag
        p_gen_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
            gen_out[i] |-> ch_ctrl[i][B_FLAG]);

        // R9: interrupt output tracks flag and enable
        p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[i] == (ch_ctrl[i][B_FLAG] && ch_ctrl[i][B_IEN]));

        // R4: load bit forces counter to load value on the next edge
        p_load_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ch_ctrl[i][B_LOAD] |=> (ch_cnt[i] == $past(ch_load[i])));

        // R12: idle channel keeps its counter
        p_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_ctrl[i][B_RUN] && !ch_ctrl[i][B_LOAD]) |=> $stable(ch_cnt[i]));

        // R10: enable-all sets the run bit everywhere
        p_enall_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_strobe && enall_bit) |=> ch_ctrl[i][B_RUN]);
    end

endmodule

bind dual_interval_timer dit_checker #(
    .CNT_W (CNT_W),
    .NCH   (NCH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_strobe (bus_wr && (bus_addr[3:2] == 2'b00)),
    .enall_bit   (bus_wdata[10]),
    .gen_out     (gen_out),
    .irq_out     (irq_out),
    .ch_ctrl     (ch_ctrl),
    .ch_load     (ch_load),
    .ch_cnt      (ch_cnt)
);

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb;

    localparam int CW   = 12;
    localparam int MAXV = (1 << CW) - 1;

    localparam logic [31:0] C_MODE  = 32'h001;
    localparam logic [31:0] C_DOWN  = 32'h002;
    localparam logic [31:0] C_GEN   = 32'h004;
    localparam logic [31:0] C_CAPT  = 32'h008;
    localparam logic [31:0] C_ARLD  = 32'h010;
    localparam logic [31:0] C_LOAD  = 32'h020;
    localparam logic [31:0] C_IEN   = 32'h040;
    localparam logic [31:0] C_RUN   = 32'h080;
    localparam logic [31:0] C_FLAG  = 32'h100;
    localparam logic [31:0] C_PWM   = 32'h200;
    localparam logic [31:0] C_ENALL = 32'h400;
    localparam logic [31:0] C_CASC  = 32'h800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  gen_out;
    logic [1:0]  irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dual_interval_timer #(.CNT_W(CW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gen_out   (gen_out),
        .irq_out   (irq_out)
    );

    function automatic int exp_period(bit down, int ld);
        return down ? (ld + 2) : (MAXV - ld + 2);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic measure(int ch, output int per);
        int w = 0;
        per = 0;
        while (!gen_out[ch] && w < 10000) begin
            @(negedge clk);
            w++;
        end
        do begin
            @(negedge clk);
            per++;
        end while (!gen_out[ch] && per < 10000);
    endtask

    task automatic run_period(int ch, bit down, int ld, string req);
        logic [4:0] base = 5'(ch * 16);
        int per;
        wr(base, C_LOAD | C_FLAG);
        wr(base + 5'd4, 32'(ld));
        wr(base, (down ? C_DOWN : 32'h0) | C_GEN | C_ARLD | C_RUN);
        measure(ch, per);
        chk(req, 32'(per), 32'(exp_period(down, ld)));
        wr(base, C_LOAD | C_FLAG);
    endtask

    task automatic count_pulses(int ch, int cycles, output int n);
        n = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (gen_out[ch]) n++;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        int p0;
        int p1;
        void'($urandom(32'd20211));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values, unmapped offsets
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), v);
            chk("R1 reset read", v, 32'h0);
        end
        chk("R1 gen idle", 32'(gen_out), 32'h0);
        chk("R1 irq idle", 32'(irq_out), 32'h0);

        // R2: stored-only bits read back, no effect
        wr(5'h00, C_CAPT);
        rd(5'h00, v); chk("R2 capture readback", v, C_CAPT);
        wr(5'h10, 32'hFFFF_F000 | C_PWM | C_CASC | C_MODE);
        rd(5'h10, v); chk("R2 stored bits", v, C_PWM | C_CASC | C_MODE);
        count_pulses(1, 6, n);
        chk("R2 no effect gen", 32'(n), 32'h0);
        rd(5'h18, v); chk("R2 no effect count", v, 32'h0);
        wr(5'h00, 32'h0);
        wr(5'h10, 32'h0);

        // R3: load truncation
        wr(5'h04, 32'h000A_BCDE);
        rd(5'h04, v); chk("R3 load truncate", v, 32'h0000_0CDE);
        wr(5'h17, 32'h0000_0123);
        rd(5'h14, v); chk("R3 load ch1 byte addr", v, 32'h123);

        // R4: load bit holds counter
        wr(5'h04, 32'd5);
        wr(5'h00, C_LOAD | C_DOWN | C_RUN);
        @(negedge clk);
        rd(5'h08, v); chk("R4 load applied", v, 32'd5);
        repeat (6) @(negedge clk);
        rd(5'h08, v); chk("R4 load held", v, 32'd5);

        // R12: counter writes ignored, idle counter frozen
        wr(5'h00, C_DOWN);
        wr(5'h08, 32'h55);
        repeat (3) @(negedge clk);
        rd(5'h08, v); chk("R12 counter write ignored", v, 32'd5);
        rd(5'h0C, v); chk("R1 unmapped 0x0C", v, 32'h0);

        // R5 / R6: directed period corners
        run_period(0, 1'b1, 0, "R5 down load0");
        run_period(0, 1'b1, 7, "R5 down load7");
        run_period(1, 1'b0, MAXV, "R6 up loadmax");
        run_period(1, 1'b0, MAXV - 9, "R6 up near max");
        run_period(0, 1'b0, 0, "R6 up longest");

        // R5 / R6: random loads, both channels
        for (int it = 0; it < 16; it++) begin
            int ch = int'($urandom_range(0, 1));
            bit dn = 1'($urandom_range(0, 1));
            int k = int'($urandom_range(0, 40));
            run_period(ch, dn, dn ? k : (MAXV - k), dn ? "R5 random" : "R6 random");
        end

        // R8 / R9 / R11: flag without generate, irq gating, clear
        wr(5'h00, C_LOAD | C_FLAG);
        wr(5'h04, 32'd2);
        wr(5'h00, C_DOWN | C_ARLD | C_RUN);
        count_pulses(0, 12, n);
        chk("R11 gen disabled", 32'(n), 32'h0);
        rd(5'h00, v); chk("R8 flag set", v & C_FLAG, C_FLAG);
        chk("R9 irq masked", 32'(irq_out[0]), 32'h0);
        wr(5'h00, C_LOAD | C_IEN);
        rd(5'h00, v); chk("R8 write0 keeps flag", v, C_LOAD | C_IEN | C_FLAG);
        chk("R9 irq asserted", 32'(irq_out[0]), 32'h1);
        wr(5'h00, C_LOAD | C_IEN | C_FLAG);
        rd(5'h00, v); chk("R8 write1 clears", v, C_LOAD | C_IEN);
        chk("R9 irq cleared", 32'(irq_out[0]), 32'h0);

        // R7: one-shot down and up
        wr(5'h04, 32'd3);
        wr(5'h00, C_LOAD | C_DOWN);
        wr(5'h00, C_DOWN | C_GEN | C_RUN);
        count_pulses(0, 20, n);
        chk("R7 one pulse down", 32'(n), 32'h1);
        rd(5'h00, v); chk("R7 run cleared down", v, C_DOWN | C_GEN | C_FLAG);
        rd(5'h08, v); chk("R7 parked at zero", v, 32'h0);
        wr(5'h14, 32'(MAXV - 2));
        wr(5'h10, C_LOAD);
        wr(5'h10, C_GEN | C_RUN);
        count_pulses(1, 20, n);
        chk("R7 one pulse up", 32'(n), 32'h1);
        rd(5'h18, v); chk("R7 parked at max", v, 32'(MAXV));
        rd(5'h10, v); chk("R7 run cleared up", v & C_RUN, 32'h0);

        // R10: enable-all from either channel
        wr(5'h00, C_LOAD | C_FLAG);
        wr(5'h10, C_LOAD | C_FLAG);
        wr(5'h00, C_LOAD | C_ENALL);
        rd(5'h00, v); chk("R10 ch0 run", v, C_LOAD | C_ENALL | C_RUN);
        rd(5'h10, v); chk("R10 ch1 run", v & C_RUN, C_RUN);
        wr(5'h00, C_LOAD);
        wr(5'h10, C_LOAD);
        wr(5'h10, C_LOAD | C_ENALL);
        rd(5'h00, v); chk("R10 from ch1", v & C_RUN, C_RUN);

        // R13: both channels running with different settings
        wr(5'h04, 32'd4);
        wr(5'h14, 32'(MAXV - 10));
        wr(5'h00, C_LOAD | C_FLAG);
        wr(5'h10, C_LOAD | C_FLAG);
        wr(5'h00, C_DOWN | C_GEN | C_ARLD | C_RUN);
        wr(5'h10, C_GEN | C_ARLD | C_RUN);
        measure(0, p0);
        measure(1, p1);
        chk("R13 ch0 period", 32'(p0), 32'(exp_period(1'b1, 4)));
        chk("R13 ch1 period", 32'(p1), 32'(exp_period(1'b0, MAXV - 10)));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule